// File: doc/BRIEF.md
# Processor-to-Host Character FIFO Bridge

The bridge moves byte streams between a processor on a 32-bit memory-mapped bus and a host-side debug link. Bytes arriving from the host over a valid/ready byte port are queued in an inbound FIFO that the processor empties by reading the data register. Bytes the processor writes to the data register are queued in an outbound FIFO that the host side empties through a second valid/ready byte port. Each FIFO holds 2^N bytes, with N a parameter from 3 to 15 (64 bytes by default).

A single level interrupt tells the processor when to act. The inbound condition is raised when the room left in the inbound FIFO has fallen to a threshold, or when at least one byte is waiting and the host says no further bytes will come. The outbound condition is raised when the bytes still waiting for the host have fallen to a threshold. Both thresholds are parameters (default 8). A sticky flag records that the host has polled the block. Software clears it by writing 1 to its bit.

The slave port decodes one word-address bit: 0 selects the data register and 1 selects the control register. Read data is registered and is valid on the cycle after the access. Reset is an asynchronous active-low input. The block synchronises its release internally, so it takes effect two clock edges after the input rises.

Top module: `chr_fifo_bridge`

## Requirements
- R1: The inbound FIFO holds at most 2^RD_AW bytes. `h_in_ready` is high exactly when it holds fewer than that. A host byte offered while it is full is discarded.
- R2: Host bytes reach the processor in arrival order. A data-register read of a non-empty inbound FIFO returns the byte in [7:0], 1 in bit 15, and in [31:16] the number of bytes still queued after this read. All other bits read 0.
- R3: A data-register read pops exactly one byte when the inbound FIFO is non-empty. When it is empty, the read returns all zeros and removes nothing.
- R4: A processor write to the data register queues bits [7:0] in the outbound FIFO. If that FIFO already holds 2^WR_AW bytes, the write is dropped.
- R5: `h_out_valid` is high exactly when the outbound FIFO is non-empty. `h_out_data` shows the oldest byte, and a cycle with `h_out_valid` and `h_out_ready` both high removes it.
- R6: The inbound pending status (control bit 8) is 1 when the free space in the inbound FIFO is at most RD_THRESH. It falls once processor reads raise that space above RD_THRESH.
- R7: The inbound pending status is also 1 whenever `h_eos` is high and the inbound FIFO holds at least one byte.
- R8: The outbound pending status (control bit 9) is 1 when the outbound FIFO holds at most WR_THRESH bytes. It falls once processor writes bring it above WR_THRESH.
- R9: `irq` equals (bit 8 AND bit 0) OR (bit 9 AND bit 1) of the control state. Pending statuses and `irq` follow FIFO counts and `h_eos` with one cycle of delay.
- R10: The host-activity flag (control bit 10) sets on a cycle with `h_poll` high and then stays set. A control write with bit 10 = 1 clears it, but a poll in the same cycle keeps it set.
- R11: A control read returns the read enable in bit 0, the write enable in bit 1, the pending statuses in bits 8 and 9, the activity flag in bit 10, and the outbound free space in [31:16]. All other bits are 0. A control write loads bits 0 and 1.
- R12: After reset both FIFOs are empty, both enables and the activity flag are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = control register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the access |
| h_in_valid | input | 1 | Host offers a byte for the inbound FIFO |
| h_in_data | input | 8 | Inbound byte |
| h_in_ready | output | 1 | Inbound FIFO can accept a byte |
| h_out_valid | output | 1 | Outbound FIFO has a byte for the host |
| h_out_data | output | 8 | Oldest outbound byte |
| h_out_ready | input | 1 | Host takes the outbound byte |
| h_eos | input | 1 | Host expects no further inbound bytes |
| h_poll | input | 1 | Host poll strobe, sets the activity flag |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives both FIFOs to their exact threshold boundaries. A design that used strict comparison, or counted used space instead of free space, would raise or drop the pending bits one byte early or late. It overfills both FIFOs and checks that the surplus byte is lost rather than wrapping over the oldest entry, and it reads an empty inbound FIFO to expose a design that pops or returns stale data. It raises `h_eos` with one byte queued, where a design lacking the end-of-stream term stays silent. It also polls in the same cycle as a clearing write, where a design that lets the clear win would lose the flag.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_CTRL = 1'b1
  } cfb_reg_e;

  // control register bit positions (software-visible)
  localparam int CTL_RIE  = 0;
  localparam int CTL_WIE  = 1;
  localparam int CTL_RPND = 8;
  localparam int CTL_WPND = 9;
  localparam int CTL_ACT  = 10;
  // data register valid flag
  localparam int DAT_VLD  = 15;

  typedef struct packed {
    logic rie;
    logic wie;
    logic act;
  } cfb_ctl_t;

endpackage

// File: rtl/cfb_rst_sync.sv
module cfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cfb_fifo.sv
module cfb_fifo #(
  parameter int AW = 6,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, wptr_d;
  logic [AW:0]  rptr_q, rptr_d;
  logic         do_push, do_pop;

  assign count   = wptr_q - rptr_q;
  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr_q[AW-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (do_push) wptr_d = wptr_q + 1'b1;
    if (do_pop)  rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  // storage carries no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q[AW-1:0]] <= din;
  end
endmodule

// File: rtl/cfb_irq.sv
module cfb_irq #(
  parameter int RD_AW     = 6,
  parameter int WR_AW     = 6,
  parameter int RD_THRESH = 8,
  parameter int WR_THRESH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [RD_AW:0] rd_cnt,
  input  logic [WR_AW:0] wr_cnt,
  input  logic         eos,
  input  logic         rie,
  input  logic         wie,
  output logic         rd_pend,
  output logic         wr_pend,
  output logic         irq
);
  localparam int RD_DEPTH = 1 << RD_AW;

  logic [RD_AW:0] rd_free;
  logic rd_pend_d, wr_pend_d, irq_d;

  assign rd_free = (RD_AW+1)'(RD_DEPTH) - rd_cnt;

  always_comb begin
    rd_pend_d = (int'(rd_free) <= RD_THRESH) || (eos && (rd_cnt != '0));
    wr_pend_d = (int'(wr_cnt) <= WR_THRESH);
    irq_d     = (rd_pend_d && rie) || (wr_pend_d && wie);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rd_pend <= rd_pend_d;
      wr_pend <= wr_pend_d;
      irq     <= irq_d;
    end
  end
endmodule

// File: rtl/chr_fifo_bridge.sv
module chr_fifo_bridge
  import cfb_pkg::*;
#(
  parameter int RD_AW     = 6,
  parameter int WR_AW     = 6,
  parameter int RD_THRESH = 8,
  parameter int WR_THRESH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        h_in_valid,
  input  logic [7:0]  h_in_data,
  output logic        h_in_ready,
  output logic        h_out_valid,
  output logic [7:0]  h_out_data,
  input  logic        h_out_ready,
  input  logic        h_eos,
  input  logic        h_poll,
  output logic        irq
);
  localparam int WR_DEPTH = 1 << WR_AW;

  logic srst_n;
  cfb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // ---------------- access decode ----------------
  cfb_reg_e sel_reg;
  logic rd_acc, wr_acc;
  logic dat_rd, dat_wr, ctl_rd, ctl_wr;

  assign sel_reg = cfb_reg_e'(bus_addr);
  assign rd_acc  = bus_sel && !bus_wr;
  assign wr_acc  = bus_sel &&  bus_wr;
  assign dat_rd  = rd_acc && (sel_reg == REG_DATA);
  assign dat_wr  = wr_acc && (sel_reg == REG_DATA);
  assign ctl_rd  = rd_acc && (sel_reg == REG_CTRL);
  assign ctl_wr  = wr_acc && (sel_reg == REG_CTRL);

  // ---------------- FIFOs ----------------
  logic [7:0]     rd_head;
  logic [RD_AW:0] rd_cnt;
  logic           rd_full, rd_empty;
  logic [WR_AW:0] wr_cnt;
  logic           wr_full, wr_empty;

  cfb_fifo #(.AW(RD_AW), .W(8)) u_rd_fifo (
    .clk(clk), .rst_n(srst_n),
    .push(h_in_valid), .din(h_in_data),
    .pop(dat_rd), .dout(rd_head),
    .count(rd_cnt), .full(rd_full), .empty(rd_empty)
  );

  cfb_fifo #(.AW(WR_AW), .W(8)) u_wr_fifo (
    .clk(clk), .rst_n(srst_n),
    .push(dat_wr), .din(bus_wdata[7:0]),
    .pop(h_out_ready), .dout(h_out_data),
    .count(wr_cnt), .full(wr_full), .empty(wr_empty)
  );

  assign h_in_ready  = !rd_full;
  assign h_out_valid = !wr_empty;

  // ---------------- control state ----------------
  cfb_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d.rie = bus_wdata[CTL_RIE];
      ctl_d.wie = bus_wdata[CTL_WIE];
      if (bus_wdata[CTL_ACT]) ctl_d.act = 1'b0;
    end
    if (h_poll) ctl_d.act = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  // ---------------- interrupt ----------------
  logic rd_pend_q, wr_pend_q;

  cfb_irq #(
    .RD_AW(RD_AW), .WR_AW(WR_AW),
    .RD_THRESH(RD_THRESH), .WR_THRESH(WR_THRESH)
  ) u_irq (
    .clk(clk), .rst_n(srst_n),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .eos(h_eos),
    .rie(ctl_q.rie), .wie(ctl_q.wie),
    .rd_pend(rd_pend_q), .wr_pend(wr_pend_q), .irq(irq)
  );

  // ---------------- read data ----------------
  logic [WR_AW:0] wr_free;
  logic [RD_AW:0] rd_left;
  logic [31:0]    dat_word, ctl_word, rdata_d;
  logic [31:0]    rdata_q;

  assign wr_free = (WR_AW+1)'(WR_DEPTH) - wr_cnt;
  assign rd_left = rd_cnt - 1'b1;

  always_comb begin
    dat_word = '0;
    if (!rd_empty) begin
      dat_word[7:0]    = rd_head;
      dat_word[DAT_VLD] = 1'b1;
      dat_word[31:16]  = 16'(rd_left);
    end
    ctl_word = '0;
    ctl_word[CTL_RIE]  = ctl_q.rie;
    ctl_word[CTL_WIE]  = ctl_q.wie;
    ctl_word[CTL_RPND] = rd_pend_q;
    ctl_word[CTL_WPND] = wr_pend_q;
    ctl_word[CTL_ACT]  = ctl_q.act;
    ctl_word[31:16]    = 16'(wr_free);
    rdata_d = ctl_rd ? ctl_word : dat_word;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     rdata_q <= '0;
    else if (rd_acc) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:11], bus_wdata[9:8], bus_wdata[7:2], wr_full};
endmodule

// File: rtl/cfb_checker.sv
module cfb_checker #(
  parameter int RD_AW     = 6,
  parameter int WR_AW     = 6,
  parameter int RD_THRESH = 8,
  parameter int WR_THRESH = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_wr,
  input logic         bus_addr,
  input logic         clr_bit,
  input logic         h_in_valid,
  input logic         h_in_ready,
  input logic         h_out_valid,
  input logic         h_out_ready,
  input logic         h_eos,
  input logic         h_poll,
  input logic [RD_AW:0] rd_cnt,
  input logic [WR_AW:0] wr_cnt,
  input logic         rd_pend,
  input logic         wr_pend,
  input logic         rie,
  input logic         wie,
  input logic         act,
  input logic         irq
);
  localparam int RD_DEPTH = 1 << RD_AW;
  localparam int WR_DEPTH = 1 << WR_AW;

  // R1
  p_rd_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_cnt) <= RD_DEPTH);
  p_in_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    h_in_ready |-> (int'(rd_cnt) != RD_DEPTH));
  // R3
  p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_addr && rd_cnt == '0 && !h_in_valid) |=> (rd_cnt == '0));
  // R4
  p_drop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr && int'(wr_cnt) == WR_DEPTH && !h_out_ready)
      |=> (int'(wr_cnt) == WR_DEPTH));
  // R5
  p_out_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    h_out_valid == (wr_cnt != '0));
  // R6
  p_rd_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((RD_DEPTH - int'(rd_cnt)) > RD_THRESH && !(h_eos && rd_cnt != '0)) |=> !rd_pend);
  // R7
  p_eos_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_eos && rd_cnt != '0) |=> rd_pend);
  // R8
  p_wr_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_cnt) > WR_THRESH) |=> !wr_pend);
  // R9
  p_no_enable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rie && !wie) |=> !irq);
  // R10
  p_poll_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    h_poll |=> act);
  p_act_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !(bus_sel && bus_wr && bus_addr && clr_bit)) |=> act);
endmodule

bind chr_fifo_bridge cfb_checker #(
  .RD_AW(RD_AW), .WR_AW(WR_AW), .RD_THRESH(RD_THRESH), .WR_THRESH(WR_THRESH)
) u_cfb_checker (
  .clk(clk), .rst_n(srst_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .clr_bit(bus_wdata[10]),
  .h_in_valid(h_in_valid), .h_in_ready(h_in_ready),
  .h_out_valid(h_out_valid), .h_out_ready(h_out_ready),
  .h_eos(h_eos), .h_poll(h_poll),
  .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
  .rd_pend(rd_pend_q), .wr_pend(wr_pend_q),
  .rie(ctl_q.rie), .wie(ctl_q.wie), .act(ctl_q.act), .irq(irq)
);

// File: tb/tb_chr_fifo_bridge.sv
`timescale 1ns/1ps
module tb_chr_fifo_bridge;
  localparam int RAW = 6, WAW = 6, RTH = 8, WTH = 8;
  localparam int RD = 1 << RAW, WD = 1 << WAW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, bus_sel, bus_wr, bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        h_in_valid, h_in_ready, h_out_valid, h_out_ready, h_eos, h_poll, irq;
  logic [7:0]  h_in_data, h_out_data;

  chr_fifo_bridge #(.RD_AW(RAW), .WR_AW(WAW), .RD_THRESH(RTH), .WR_THRESH(WTH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .h_in_valid(h_in_valid),
    .h_in_data(h_in_data), .h_in_ready(h_in_ready), .h_out_valid(h_out_valid),
    .h_out_data(h_out_data), .h_out_ready(h_out_ready), .h_eos(h_eos),
    .h_poll(h_poll), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rdq[$], wrq[$];
  bit m_rie, m_wie, m_act, m_eos;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit exp_rpend();
    return ((RD - rdq.size()) <= RTH) || (m_eos && rdq.size() != 0);
  endfunction
  function automatic bit exp_wpend();
    return wrq.size() <= WTH;
  endfunction
  function automatic logic [31:0] exp_ctrl();
    return {16'(WD - wrq.size()), 5'b0, m_act, exp_wpend(), exp_rpend(), 6'b0, m_wie, m_rie};
  endfunction

  task automatic host_push(logic [7:0] b);
    @(negedge clk);
    check("R1 in_ready", 32'(h_in_ready), 32'(rdq.size() < RD));
    h_in_valid = 1; h_in_data = b;
    @(negedge clk);
    h_in_valid = 0;
    if (rdq.size() < RD) rdq.push_back(b);
  endtask

  task automatic host_pop();
    @(negedge clk);
    check("R5 out_valid", 32'(h_out_valid), 32'(wrq.size() != 0));
    if (wrq.size() != 0) check("R5 out_data", 32'(h_out_data), 32'(wrq[0]));
    h_out_ready = 1;
    @(negedge clk);
    h_out_ready = 0;
    if (wrq.size() != 0) void'(wrq.pop_front());
  endtask

  task automatic bus_rd(logic a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; bus_sel = 0;
  endtask

  task automatic bus_wrt(logic a, logic [31:0] d, bit poll);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; h_poll = poll;
    @(negedge clk);
    bus_sel = 0; h_poll = 0;
    if (!a) begin
      if (wrq.size() < WD) wrq.push_back(d[7:0]);
    end else begin
      m_rie = d[0]; m_wie = d[1];
      if (d[10]) m_act = 0;
    end
    if (poll) m_act = 1;
  endtask

  task automatic data_read();
    logic [31:0] e, d;
    if (rdq.size() != 0) begin
      e = {16'(rdq.size() - 1), 1'b1, 7'b0, rdq[0]};
      void'(rdq.pop_front());
    end else e = 32'h0;
    bus_rd(1'b0, d);
    check("R2 R3 data read", d, e);
  endtask

  task automatic poll();
    @(negedge clk); h_poll = 1;
    @(negedge clk); h_poll = 0; m_act = 1;
  endtask

  task automatic settle_check();
    logic [31:0] d;
    @(negedge clk);
    check("R9 irq", 32'(irq), 32'((exp_rpend() && m_rie) || (exp_wpend() && m_wie)));
    bus_rd(1'b1, d);
    check("R11 ctrl (R6 R7 R8 R10)", d, exp_ctrl());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    logic [31:0] d;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    h_in_valid = 0; h_in_data = 0; h_out_ready = 0; h_eos = 0; h_poll = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 irq", 32'(irq), 32'h0);
    check("R12 in_ready", 32'(h_in_ready), 32'h1);
    check("R12 out_valid", 32'(h_out_valid), 32'h0);
    bus_rd(1'b1, d);
    check("R12 ctrl", d, 32'h0040_0200);
    data_read();  // R3 empty read

    // R1 R6: fill inbound to the threshold boundary, then full, then overfill
    bus_wrt(1'b1, 32'h1, 0);
    for (int i = 0; i < RD - RTH - 1; i++) host_push(8'(i + 3));
    settle_check();                // free = RTH+1: not pending
    host_push(8'hA5);
    settle_check();                // free = RTH: pending
    while (rdq.size() < RD) host_push(8'($urandom));
    host_push(8'hEE);              // discarded (R1)
    settle_check();
    data_read();                   // R6 free RTH+1 after reads
    for (int i = 0; i < RTH; i++) data_read();
    settle_check();
    while (rdq.size() != 0) data_read();
    data_read();                   // R3 empty again

    // R7 end-of-stream with one byte queued
    h_eos = 1; m_eos = 1;
    settle_check();                // empty: not pending
    host_push(8'h42);
    settle_check();                // one byte + eos: pending
    data_read();
    h_eos = 0; m_eos = 0;
    settle_check();

    // R4 R8: outbound threshold boundary and overflow
    bus_wrt(1'b1, 32'h2, 0);
    for (int i = 0; i < WTH; i++) bus_wrt(1'b0, 32'(i + 16), 0);
    settle_check();                // count WTH: pending
    bus_wrt(1'b0, 32'h77, 0);
    settle_check();                // count WTH+1: cleared
    while (wrq.size() < WD) bus_wrt(1'b0, 32'($urandom), 0);
    bus_wrt(1'b0, 32'hDD, 0);      // dropped (R4)
    settle_check();
    while (wrq.size() != 0) host_pop();
    host_pop();
    settle_check();

    // R10 activity flag: set, sticky, clear, poll wins over clear
    poll();
    bus_wrt(1'b1, 32'h0, 0);
    settle_check();
    bus_wrt(1'b1, 32'h400, 0);
    settle_check();
    bus_wrt(1'b1, 32'h403, 1);
    settle_check();

    // constrained random mix
    for (int i = 0; i < 1500; i++) begin
      int op;
      op = int'($urandom_range(0, 99));
      if (i >= 750) op = (op < 20) ? op + 40 : op;  // drain-leaning second half
      if (op < 25)       host_push(8'($urandom));
      else if (op < 40)  bus_wrt(1'b0, $urandom, 0);
      else if (op < 60)  data_read();
      else if (op < 75)  host_pop();
      else if (op < 83)  bus_wrt(1'b1, $urandom & 32'h0000_0403, ($urandom_range(0, 3) == 0));
      else if (op < 88)  poll();
      else if (op < 93)  begin @(negedge clk); h_eos = ~h_eos; m_eos = h_eos; end
      else               settle_check();
      if (i % 8 == 0) settle_check();
    end
    settle_check();
    finish_run();
  end
endmodule